// File: doc/BRIEF.md
# Fine-Grained Multithreaded Issue Scheduler

This block picks, on every clock, one hardware thread context out of a pool of up to 128 and grants issue to that thread's next instruction. Selection rotates round-robin over the threads that are ready. The thread granted last is never granted in the following cycle, so a single thread cannot monopolise consecutive issue slots. Threads whose context is not active are skipped. Threads that wait on an outstanding memory load are also skipped.

The fetch stage presents each thread's next instruction to the scheduler as a load flag and a lookahead count. The lookahead count says how many later instructions of the same thread do not depend on that instruction. When a thread issues a load, it may keep issuing non-load instructions until this budget is used up. It then stalls until the memory system returns a response tagged with its thread number. Long memory latency is hidden by filling the slots of a stalled thread with instructions from other threads.

The block issues at most one instruction per cycle. The datapath, register files and instruction fetch are outside the block.

Top module: `mt_issue_sched`

## Requirements
- R1: After reset no thread has a load outstanding. The first grant goes to the lowest-numbered ready thread.
- R2: The grant goes to the first ready thread with a number strictly above the last granted thread. The search wraps from the highest thread number to 0.
- R3: A thread is never granted in two consecutive cycles. When only one thread is ready, it is granted every other cycle.
- R4: A thread whose active bit is 0 is never granted. `iss_vld_o` is 0 in any cycle with no eligible thread.
- R5: A granted load with lookahead L lets its thread issue at most L further non-load instructions. After those, the thread gets no grant until its memory return arrives.
- R6: While a thread's load is outstanding, a next instruction that is itself a load keeps the thread ungranted, even if lookahead budget remains.
- R7: A memory return with `ret_vld_i`=1 and `ret_tid_i`=t clears thread t's outstanding load. Thread t can be granted in the very next cycle.
- R8: A load with lookahead 0 blocks its thread right after it issues, until its return.
- R9: Thread t's next-instruction load flag is bit t of `nxt_ld_i`. Its lookahead count is `nxt_la_i[t*LA_W +: LA_W]`. Its active bit is bit t of `act_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | NTHR | Per-thread context active |
| nxt_ld_i | input | NTHR | Per-thread next instruction is a load |
| nxt_la_i | input | NTHR*LA_W | Per-thread lookahead count of the next instruction |
| ret_vld_i | input | 1 | Memory return valid |
| ret_tid_i | input | TID_W | Thread number of the memory return |
| iss_vld_o | output | 1 | A thread is granted this cycle |
| iss_tid_o | output | TID_W | Granted thread number |

## Verification
The round-robin choice is tried with three patterns, and each one isolates a different rule:
- With every thread active, the bench sees the rotation order and the wrap from the top thread back to 0.
- With a sparse set of active threads, it sees inactive threads being skipped.
- With a single active thread, it sees the rule against back-to-back grants.

The wait logic is tried with three load cases:
- A load with a nonzero lookahead shows that independent instructions of the thread are counted.
- A load with lookahead zero shows that the thread blocks at once.
- A second load inside the lookahead window shows that loads stall even when budget remains.

In each load case, the grant that follows the tagged return shows that the thread wakes in the next cycle.

// File: rtl/mt_issue_pkg.sv
package mt_issue_pkg;
  typedef enum logic {
    CTX_FREE = 1'b0,
    CTX_WAIT = 1'b1
  } ctx_mode_e;
endpackage

// File: rtl/mt_thread_ctx.sv
module mt_thread_ctx
  import mt_issue_pkg::*;
#(
  parameter int LA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic            nxt_ld_i,
  input  logic [LA_W-1:0] nxt_la_i,
  input  logic            iss_me_i,
  input  logic            ret_me_i,
  output logic            rdy_o
);

  ctx_mode_e       mode_q, mode_d;
  logic [LA_W-1:0] bud_q, bud_d;
  logic            upd_en;

  // Eligible when free, or waiting with budget left and an independent non-load next.
  assign rdy_o = act_i & ((mode_q == CTX_FREE) |
                          ((bud_q != '0) & ~nxt_ld_i));

  assign upd_en = iss_me_i | ret_me_i;

  always_comb begin
    mode_d = mode_q;
    bud_d  = bud_q;
    if (iss_me_i && (mode_q == CTX_WAIT)) bud_d = bud_q - 1'b1;
    if (ret_me_i) mode_d = CTX_FREE;
    if (iss_me_i && nxt_ld_i) begin
      mode_d = CTX_WAIT;
      bud_d  = nxt_la_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CTX_FREE;
      bud_q  <= '0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      bud_q  <= bud_d;
    end
  end

  // R5: exhausted budget forbids a grant to this thread
  p_zero_budget_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CTX_WAIT && bud_q == '0) |-> !iss_me_i);

  // R5: an independent issue under a pending load spends one unit of budget
  p_budget_spend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_me_i && mode_q == CTX_WAIT && !ret_me_i) |=> bud_q == $past(bud_q) - LA_W'(1));

  // R6: no second load while one is outstanding
  p_load_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CTX_WAIT && nxt_ld_i) |-> !iss_me_i);

  // R7: a tagged return frees the thread
  p_return_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_me_i && !(iss_me_i && nxt_ld_i)) |=> mode_q == CTX_FREE);

endmodule

// File: rtl/mt_rr_arb.sv
module mt_rr_arb #(
  parameter int NTHR  = 128,
  parameter int TID_W = $clog2(NTHR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  req_i,
  output logic             vld_o,
  output logic [TID_W-1:0] tid_o
);

  logic [TID_W-1:0] lst_q, lst_d;
  logic             lst_vld_q;
  logic [NTHR-1:0]  excl, req_eff, above, req_hi;

  function automatic logic [TID_W-1:0] lowest_set(input logic [NTHR-1:0] v);
    logic [TID_W-1:0] r;
    r = '0;
    for (int i = NTHR - 1; i >= 0; i--) begin
      if (v[i]) r = TID_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    excl = '0;
    if (lst_vld_q) excl[lst_q] = 1'b1;
    for (int i = 0; i < NTHR; i++) above[i] = (i > int'(lst_q));
  end

  assign req_eff = req_i & ~excl;
  assign req_hi  = req_eff & above;
  assign vld_o   = |req_eff;
  assign tid_o   = (|req_hi) ? lowest_set(req_hi) : lowest_set(req_eff);

  always_comb begin
    lst_d = lst_q;
    if (vld_o) lst_d = tid_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lst_q     <= TID_W'(NTHR - 1);
      lst_vld_q <= 1'b0;
    end else begin
      lst_q     <= lst_d;
      lst_vld_q <= vld_o;
    end
  end

  // R4: a grant is only given to a requesting thread
  p_grant_requested_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> req_i[tid_o]);

  // R3: no back-to-back grant to the same thread
  p_no_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && lst_vld_q) |-> tid_o != lst_q);

endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched
  import mt_issue_pkg::*;
#(
  parameter int NTHR  = 128,
  parameter int LA_W  = 3,
  parameter int TID_W = $clog2(NTHR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTHR-1:0]      act_i,
  input  logic [NTHR-1:0]      nxt_ld_i,
  input  logic [NTHR*LA_W-1:0] nxt_la_i,
  input  logic                 ret_vld_i,
  input  logic [TID_W-1:0]     ret_tid_i,
  output logic                 iss_vld_o,
  output logic [TID_W-1:0]     iss_tid_o
);

  logic [NTHR-1:0] rdy;

  for (genvar g = 0; g < NTHR; g++) begin : g_ctx
    logic iss_me, ret_me;
    assign iss_me = iss_vld_o & (iss_tid_o == TID_W'(g));
    assign ret_me = ret_vld_i & (ret_tid_i == TID_W'(g));

    mt_thread_ctx #(.LA_W(LA_W)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (act_i[g]),
      .nxt_ld_i (nxt_ld_i[g]),
      .nxt_la_i (nxt_la_i[g*LA_W +: LA_W]),
      .iss_me_i (iss_me),
      .ret_me_i (ret_me),
      .rdy_o    (rdy[g])
    );
  end

  mt_rr_arb #(.NTHR(NTHR), .TID_W(TID_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (rdy),
    .vld_o (iss_vld_o),
    .tid_o (iss_tid_o)
  );

  // R4: inactive contexts never issue
  p_active_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld_o |-> act_i[iss_tid_o]);

endmodule

// File: tb/mt_issue_sched_tb.sv
module mt_issue_sched_tb;
  localparam int NTHR  = 8;
  localparam int LA_W  = 3;
  localparam int TID_W = 3;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NTHR-1:0]      act_i;
  logic [NTHR-1:0]      nxt_ld_i;
  logic [NTHR*LA_W-1:0] nxt_la_i;
  logic                 ret_vld_i;
  logic [TID_W-1:0]     ret_tid_i;
  logic                 iss_vld_o;
  logic [TID_W-1:0]     iss_tid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mt_issue_sched #(.NTHR(NTHR), .LA_W(LA_W), .TID_W(TID_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (act_i),
    .nxt_ld_i  (nxt_ld_i),
    .nxt_la_i  (nxt_la_i),
    .ret_vld_i (ret_vld_i),
    .ret_tid_i (ret_tid_i),
    .iss_vld_o (iss_vld_o),
    .iss_tid_o (iss_tid_o)
  );

  task automatic do_reset(input logic [NTHR-1:0] act);
    rst_n     = 1'b0;
    act_i     = act;
    nxt_ld_i  = '0;
    nxt_la_i  = '0;
    ret_vld_i = 1'b0;
    ret_tid_i = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // One cycle: check at the falling edge, return just after the next rising edge.
  task automatic step(input logic ev, input int et, input string rq);
    @(negedge clk);
    checks++;
    if (iss_vld_o !== ev || (ev && iss_tid_o !== TID_W'(et))) begin
      fails++;
      $display("FAIL %s: got vld=%0b tid=%0d, expected vld=%0b tid=%0d",
               rq, iss_vld_o, iss_tid_o, ev, et);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_idle;
    do_reset('0);
    step(1'b0, 0, "R4 no active thread");
  endtask

  task automatic t_all_active;
    do_reset('1);
    step(1'b1, 0, "R1 first grant lowest");
    for (int i = 1; i < NTHR; i++) step(1'b1, i, "R2 rotation");
    step(1'b1, 0, "R2 wrap to zero");
  endtask

  task automatic t_sparse;
    do_reset(8'b0010_0100);
    step(1'b1, 2, "R4 skip inactive");
    step(1'b1, 5, "R2 next above last");
    step(1'b1, 2, "R2 wrap sparse");
    step(1'b1, 5, "R4 skip inactive");
  endtask

  task automatic t_single;
    do_reset(8'b0000_1000);
    step(1'b1, 3, "R3 single thread");
    step(1'b0, 0, "R3 no back-to-back");
    step(1'b1, 3, "R3 single thread");
    step(1'b0, 0, "R3 no back-to-back");
  endtask

  // R5 / R9: thread 0 load, lookahead 2 in bits [2:0]
  task automatic t_lookahead;
    do_reset(8'b0000_0011);
    nxt_ld_i[0] = 1'b1;
    nxt_la_i[2:0] = 3'd2;
    step(1'b1, 0, "R5 load issues");
    nxt_ld_i[0] = 1'b0;
    step(1'b1, 1, "R2 other thread");
    step(1'b1, 0, "R5 first independent");
    step(1'b1, 1, "R2 other thread");
    step(1'b1, 0, "R5 second independent");
    step(1'b1, 1, "R2 other thread");
    step(1'b0, 0, "R5 budget exhausted");
    step(1'b1, 1, "R5 other thread continues");
    ret_vld_i = 1'b1;
    ret_tid_i = 3'd0;
    step(1'b0, 0, "R5 still blocked");
    ret_vld_i = 1'b0;
    step(1'b1, 0, "R7 wake after return");
  endtask

  // R8 / R9: thread 4 load, lookahead 0 in bits [14:12]
  task automatic t_zero_la;
    do_reset(8'b0001_0000);
    nxt_ld_i[4] = 1'b1;
    nxt_la_i[14:12] = 3'd0;
    step(1'b1, 4, "R8 load issues");
    nxt_ld_i[4] = 1'b0;
    step(1'b0, 0, "R8 blocked");
    step(1'b0, 0, "R8 still blocked");
    ret_vld_i = 1'b1;
    ret_tid_i = 3'd4;
    step(1'b0, 0, "R8 blocked in return cycle");
    ret_vld_i = 1'b0;
    step(1'b1, 4, "R7 wake after return");
  endtask

  // R6: thread 6 load with budget 3, next instruction also a load
  task automatic t_load_in_window;
    do_reset(8'b0100_0000);
    nxt_ld_i[6] = 1'b1;
    nxt_la_i[20:18] = 3'd3;
    step(1'b1, 6, "R6 first load");
    step(1'b0, 0, "R6 no grant after first load");
    ret_vld_i = 1'b1;
    ret_tid_i = 3'd6;
    step(1'b0, 0, "R6 second load held");
    ret_vld_i = 1'b0;
    step(1'b1, 6, "R7 second load after return");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_idle();
    t_all_active();
    t_sparse();
    t_single();
    t_lookahead();
    t_zero_la();
    t_load_in_window();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule